// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is a 16-bit PWM time base with thirteen compare registers. Software writes a register through a simple write port. The counter never sees that written value directly. Each register feeds an internal active copy, and every compare uses the active copies.

Register 0 sets the period. Its active copy changes only at a safe point in the count, so a period change never cuts a cycle short or stretches it. Registers 1 to 12 are secondary compare points. Their active copies follow a write one clock later, whatever the counter is doing.

Two counting shapes are offered. The sawtooth shape counts up and wraps. The triangular shape counts up to the period value and back down. Each channel drives a one-cycle match pulse. A reload-status output is provided for the wider timer family; in this update policy it stays low.

Top module: `pwm_cmpbuf`

## Requirements
- R1: After reset the count is 0, every match output is low, and every active compare copy is 0x0000. When counting is first enabled with no transfer yet, all thirteen match bits are high while the count is 0.
- R2: With `tri_mode`=0 (sawtooth), the count rises by one per clock from 0. On the clock after it equals active register 0, it returns to 0.
- R3: With `tri_mode`=1 (triangular), the count rises to active register 0 and then falls by one per clock to 0. It then rises again.
- R4: A write to address 1..12 reaches that channel's active copy on the second rising edge that counts the write edge. A match on the new value is possible from the cycle after that edge, never earlier.
- R5: Bit i of `match_irq` (bit 0 = register 0, bit i = register i) is high in exactly those cycles in which `cnt_en` is 1 and the count equals active register i.
- R6: In sawtooth mode, a write to address 0 reaches the active period only on an edge where the running count equals the current active period. The period in progress therefore completes with the old value, and the next one uses the new value.
- R7: In triangular mode, a write to address 0 reaches the active period only at a peak (count equals the period while rising) or at a valley (count 0 while falling).
- R8: `reload_busy` is 0 in every cycle.
- R9: When address 0 is written more than once before a transfer point, only the last value is transferred.
- R10: With `cnt_en`=0 the count is 0 from the next edge and all match bits are low. All active copies keep their contents across the stop.
- R11: Writes to addresses 13 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | 1 = count, 0 = hold count at 0 |
| tri_mode | input | 1 | 0 = sawtooth, 1 = triangular; change only while stopped |
| wr_en | input | 1 | Write strobe for one register |
| wr_addr | input | 4 | Register index: 0 period, 1..12 secondary |
| wr_data | input | 16 | Value to write, 0x0000..0xFFFF |
| count | output | 16 | Current count |
| match_irq | output | 13 | One match pulse per compare channel |
| reload_busy | output | 1 | Reload-status flag, always 0 here |

## Verification
The hardest situation to reach is a period write that lands while a period is in progress, and in particular two such writes before the transfer point. The stimulus runs the counter and waits for a chosen count value. It then issues the writes on consecutive clocks and checks the count exactly at the old terminal value, at the wrap, and at the new terminal value.

The one-clock latency of the secondary channels is pinned down from both sides. One write targets the count value reached one clock after the write edge, so that match must be missed. Another targets the value reached two clocks after it, so that match must be hit. For the triangular mode, a period write is placed on the rising slope so that it has to wait for the following peak.

// File: rtl/pwm_cmpbuf_pkg.sv
package pwm_cmpbuf_pkg;

  localparam int CW = 16;

  typedef logic [CW-1:0] cnt_t;

  typedef enum logic {
    SHAPE_SAW = 1'b0,
    SHAPE_TRI = 1'b1
  } shape_e;

  // Safe point at which the period copy may take a staged value
  function automatic logic reload_point(shape_e shape, logic run, logic up,
                                        cnt_t cnt, cnt_t top);
    if (!run) return 1'b0;
    if (shape == SHAPE_SAW) return cnt == top;
    return (up && cnt == top) || (!up && cnt == '0);
  endfunction

  // Count after the next edge; top_nxt is the period in force after that edge
  function automatic cnt_t next_count(shape_e shape, logic up, cnt_t cnt,
                                      cnt_t top, cnt_t top_nxt);
    cnt_t r;
    if (shape == SHAPE_SAW)
      r = (cnt == top) ? '0 : cnt + cnt_t'(1);
    else if (up)
      r = (cnt != top) ? cnt + cnt_t'(1) : ((top == '0) ? '0 : cnt - cnt_t'(1));
    else
      r = (cnt != '0) ? cnt - cnt_t'(1) : ((top_nxt == '0) ? '0 : cnt_t'(1));
    return r;
  endfunction

  function automatic logic next_up(shape_e shape, logic up, cnt_t cnt, cnt_t top);
    if (shape == SHAPE_SAW) return 1'b1;
    if (up) return cnt != top;
    return cnt == '0;
  endfunction

endpackage

// File: rtl/pwm_cmpbuf_counter.sv
module pwm_cmpbuf_counter
  import pwm_cmpbuf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  shape_e shape,
  input  cnt_t   top,
  input  cnt_t   top_nxt,
  output cnt_t   cnt,
  output logic   up,
  output logic   peak,
  output logic   valley,
  output logic   reload_pt
);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= next_count(shape, up, cnt, top, top_nxt);
      up  <= next_up(shape, up, cnt, top);
    end
  end

  assign peak      = run && (shape == SHAPE_TRI) && up && (cnt == top);
  assign valley    = run && (shape == SHAPE_TRI) && !up && (cnt == '0);
  assign reload_pt = reload_point(shape, run, up, cnt, top);

endmodule

// File: rtl/pwm_cmpbuf_period.sv
module pwm_cmpbuf_period
  import pwm_cmpbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cnt_t wdata,
  input  logic reload_pt,
  output cnt_t top,
  output cnt_t top_nxt,
  output logic pending
);

  cnt_t held;

  // the transfer takes the value staged before this edge; a write on the
  // same edge stays staged for the next safe point
  assign top_nxt = (reload_pt && pending) ? held : top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= '0;
      top     <= '0;
      pending <= 1'b0;
    end else begin
      top     <= top_nxt;
      pending <= wr | (pending & ~reload_pt);
      if (wr) held <= wdata;
    end
  end

endmodule

// File: rtl/pwm_cmpbuf_chan.sv
module pwm_cmpbuf_chan
  import pwm_cmpbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cnt_t wdata,
  output cnt_t active
);

  cnt_t staged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '0;
      active <= '0;
    end else begin
      if (wr) staged <= wdata;
      active <= staged;
    end
  end

endmodule

// File: rtl/pwm_cmpbuf.sv
module pwm_cmpbuf
  import pwm_cmpbuf_pkg::*;
#(
  parameter  int NCMP = 13,
  localparam int AW   = $clog2(NCMP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            tri_mode,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  output logic [CW-1:0]   count,
  output logic [NCMP-1:0] match_irq,
  output logic            reload_busy
);

  shape_e          shape;
  logic [NCMP-1:0] wsel;
  cnt_t [NCMP-1:0] live_cmp;
  cnt_t            cnt_q;
  cnt_t            top_nxt;
  logic            cur_up;
  logic            peak_ev;
  logic            valley_ev;
  logic            xfer_ev;
  logic            period_pending;

  assign shape = shape_e'(tri_mode);

  for (genvar i = 0; i < NCMP; i++) begin : g_dec
    assign wsel[i] = wr_en && (wr_addr == AW'(i));
  end

  pwm_cmpbuf_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cnt_en),
    .shape     (shape),
    .top       (live_cmp[0]),
    .top_nxt   (top_nxt),
    .cnt       (cnt_q),
    .up        (cur_up),
    .peak      (peak_ev),
    .valley    (valley_ev),
    .reload_pt (xfer_ev)
  );

  pwm_cmpbuf_period u_per (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wsel[0]),
    .wdata     (wr_data),
    .reload_pt (xfer_ev),
    .top       (live_cmp[0]),
    .top_nxt   (top_nxt),
    .pending   (period_pending)
  );

  for (genvar i = 1; i < NCMP; i++) begin : g_chan
    pwm_cmpbuf_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wsel[i]),
      .wdata  (wr_data),
      .active (live_cmp[i])
    );
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_irq
    assign match_irq[i] = cnt_en && (cnt_q == live_cmp[i]);
  end

  assign count       = cnt_q;
  assign reload_busy = 1'b0;

endmodule

// File: rtl/pwm_cmpbuf_chk.sv
module pwm_cmpbuf_chk
  import pwm_cmpbuf_pkg::*;
#(
  parameter  int NCMP = 13,
  localparam int AW   = $clog2(NCMP)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cnt_en,
  input logic            tri_mode,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [CW-1:0]   wr_data,
  input logic [CW-1:0]   count,
  input logic [NCMP-1:0] match_irq,
  input cnt_t [NCMP-1:0] live_cmp,
  input logic            cur_up,
  input logic            peak,
  input logic            valley
);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !tri_mode && count == live_cmp[0] |=> count == '0);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !tri_mode && count != live_cmp[0] |=> count == cnt_t'($past(count) + 1'b1));

  a_r3_turn: assert property (@(posedge clk) disable iff (!rst_n)
    peak && live_cmp[0] != '0 |=> !cur_up && count == cnt_t'($past(count) - 1'b1));

  a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valley |=> cur_up);

  for (genvar g = 1; g < NCMP; g++) begin : g_lat
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == AW'(g) |=> ##1 live_cmp[g] == $past(wr_data, 2));
  end

  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> match_irq == '0);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_mode && !(cnt_en && count == live_cmp[0]) |=> $stable(live_cmp[0]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tri_mode && !peak && !valley |=> $stable(live_cmp[0]));

  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> count == '0);

endmodule

bind pwm_cmpbuf pwm_cmpbuf_chk #(.NCMP(NCMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .tri_mode  (tri_mode),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .count     (count),
  .match_irq (match_irq),
  .live_cmp  (live_cmp),
  .cur_up    (cur_up),
  .peak      (peak_ev),
  .valley    (valley_ev)
);

// File: tb/pwm_cmpbuf_tb.sv
module pwm_cmpbuf_tb;

  localparam int N = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        tri_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [N-1:0] match_irq;
  logic        reload_busy;

  pwm_cmpbuf u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tri_mode(tri_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .match_irq(match_irq), .reload_busy(reload_busy)
  );

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  typedef struct { int cyc; int kind; int val; string req; } exp_t;
  exp_t sb[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench-side expectation of the timer, built from the requirements
  int m_cnt = 0; bit m_up = 1; bit m_pend = 0;
  int m_b[N]; int m_r[N];

  function automatic void push(int c, int k, int v, string r);
    exp_t e; e.cyc = c; e.kind = k; e.val = v; e.req = r;
    sb.push_back(e);
  endfunction

  function automatic void model_edge();
    bit ev; int nb0;
    if (!cnt_en) ev = 0;
    else if (!tri_mode) ev = (m_cnt == m_b[0]);
    else ev = m_up ? (m_cnt == m_b[0]) : (m_cnt == 0);
    nb0 = (ev && m_pend) ? m_r[0] : m_b[0];
    if (!cnt_en) begin m_cnt = 0; m_up = 1; end
    else if (!tri_mode) m_cnt = (m_cnt == m_b[0]) ? 0 : m_cnt + 1;
    else if (m_up) begin
      if (m_cnt == m_b[0]) begin m_up = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
      else m_cnt = m_cnt + 1;
    end else begin
      if (m_cnt == 0) begin m_up = 1; m_cnt = (nb0 == 0) ? 0 : 1; end
      else m_cnt = m_cnt - 1;
    end
    for (int i = 1; i < N; i++) m_b[i] = m_r[i];
    m_b[0] = nb0;
    if (ev) m_pend = 0;
    if (wr_en && int'(wr_addr) < N) begin   // R11: 13..15 ignored
      m_r[wr_addr] = int'(wr_data);
      if (wr_addr == 0) m_pend = 1;
    end
  endfunction

  task automatic tick(input bit en, input bit md, input bit we, input int ad, input int dt);
    int mask;
    @(posedge clk);
    cyc++;
    model_edge();
    #2;
    cnt_en = en; tri_mode = md; wr_en = we; wr_addr = 4'(ad); wr_data = 16'(dt);
    mask = 0;
    for (int i = 0; i < N; i++) if (en && m_cnt == m_b[i]) mask |= (1 << i);
    push(cyc, 0, m_cnt, !en ? "R10" : (md ? "R3" : "R2"));
    push(cyc, 1, mask, "R5");
    push(cyc, 2, 0, "R8");
  endtask

  function automatic int actual(int k);
    if (k == 0) return int'(count);
    if (k == 1) return int'(match_irq);
    if (k == 2) return int'(reload_busy);
    return int'(match_irq[k-16]);
  endfunction

  task automatic direct(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // monitor: compare scoreboard items due in this cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int k = sb.size() - 1; k >= 0; k--) begin
        if (sb[k].cyc <= cyc) begin
          n_chk++;
          if (sb[k].cyc < cyc || actual(sb[k].kind) != sb[k].val) begin
            n_bad++;
            $display("FAIL %s: cycle %0d kind %0d actual %0h expected %0h",
                     sb[k].req, sb[k].cyc, sb[k].kind, actual(sb[k].kind), sb[k].val);
          end
          sb.delete(k);
        end
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual 200000 cycles, expected completion");
    summary();
  end

  initial begin
    int w, e;
    for (int i = 0; i < N; i++) begin m_b[i] = 0; m_r[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    direct("R1 count", int'(count), 0);
    direct("R1 irq", int'(match_irq), 0);
    direct("R8 flag", int'(reload_busy), 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R1: period staged while stopped, every copy still zero at enable
    tick(0, 0, 1, 0, 5);
    tick(1, 0, 0, 0, 0);
    push(cyc, 1, 13'h1FFF, "R1");
    repeat (14) tick(1, 0, 0, 0, 0);

    // R6 / R9: two period writes mid-period, last one wins at the wrap
    do tick(1, 0, 0, 0, 0); while (m_cnt != 1);
    tick(1, 0, 1, 0, 9); w = cyc;
    tick(1, 0, 1, 0, 3);
    push(w + 3, 0, 5, "R6"); push(w + 4, 0, 0, "R6");
    push(w + 7, 0, 3, "R9"); push(w + 8, 0, 0, "R9");
    repeat (10) tick(1, 0, 0, 0, 0);

    // R4: write at count 1 for value 2 misses, later hit; value 3 hits
    do tick(1, 0, 0, 0, 0); while (m_cnt != 0);
    tick(1, 0, 1, 3, 2); w = cyc;
    push(w + 1, 16 + 3, 0, "R4"); push(w + 5, 16 + 3, 1, "R4");
    repeat (6) tick(1, 0, 0, 0, 0);
    do tick(1, 0, 0, 0, 0); while (m_cnt != 0);
    tick(1, 0, 1, 9, 3); w = cyc;
    push(w + 2, 16 + 9, 1, "R4");
    repeat (4) tick(1, 0, 0, 0, 0);

    // R11: out-of-range addresses
    tick(1, 0, 1, 13, 0);
    tick(1, 0, 1, 15, 1);
    repeat (6) tick(1, 0, 0, 0, 0);

    // R10: stop then restart, copies retained
    repeat (3) tick(0, 0, 0, 0, 0);
    push(cyc, 0, 0, "R10");
    tick(1, 0, 0, 0, 0); e = cyc;
    push(e + 2, 16 + 3, 1, "R10");
    repeat (8) tick(1, 0, 0, 0, 0);

    // R3 / R7: triangular, staged period and a write on the rising slope
    tick(0, 1, 0, 0, 0);
    tick(0, 1, 1, 0, 4);
    tick(1, 1, 0, 0, 0); e = cyc;
    push(e + 3, 0, 3, "R3"); push(e + 4, 0, 2, "R7"); push(e + 10, 0, 4, "R7");
    push(e + 11, 0, 3, "R7"); push(e + 16, 0, 2, "R7"); push(e + 17, 0, 1, "R7");
    for (int k = 1; k <= 24; k++) tick(1, 1, (k == 8), 0, 2);

    repeat (3) tick(0, 0, 0, 0, 0);
    @(negedge clk); #1;
    direct("R5 scoreboard drained", sb.size(), 0);
    summary();
  end

endmodule